// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a parallel RGB panel. Software programs the horizontal and vertical geometry as running boundaries: the last sync count, the last back-porch count, the last active count and the last count of the line or frame. From those the block runs a pixel counter and a line counter and drives horizontal sync, vertical sync and data enable, each with its own polarity. It also reports the current pixel position and a pixel-clock inversion select.

All timing words and a set of layer configuration words are double-buffered. Writes land in a staging copy, and a reload request moves every staged word into the working copy at once. The move happens either on the next cycle or at the wrap from the last pixel of a frame to the first. A four-source sticky status word collects a programmable line event, a FIFO underrun pulse, a transfer-error pulse and reload completion. Software can mask each source and clear it by writing ones. The interrupt output stays high while any unmasked flag is set.

Top module: `disp_timing_gen`

## Requirements
- R1: While bit 0 of the control word (word address 0x0) is 0, the pixel and line counters hold at 0 and all three sync/enable outputs sit at their inactive level, which is the inverse of their polarity bit.
- R2: Horizontal fields sit in bits 27:16 of each timing word. The pixel counter runs from 0 up to the working total-width field (word 0x4) inclusive and then returns to 0. The horizontal sync is active while the count is at or below the sync field of word 0x1, which holds the sync length minus one.
- R3: Vertical fields sit in bits 10:0. The line counter advances each time the pixel counter wraps and returns to 0 after the total-height field. The vertical sync is active while the line count is at or below the vertical sync field.
- R4: Data enable is active only when the pixel count is above the horizontal back-porch boundary (word 0x2) and at or below the active-width boundary (word 0x3), and the line count meets the same test on the vertical fields.
- R5: In the control word, bit 31 sets horizontal sync, bit 30 vertical sync and bit 29 data enable to active high when 1 and active low when 0. Bit 28 drives the pixel-clock inversion output. All four reset to 0.
- R6: Writing 1 to bit 0 of the reload word (0x5) copies every staged word into the working set on the following cycle. Reading 0x5 returns the pending request bits {bit1, bit0}, and those bits clear once the copy is made.
- R7: Writing 1 to bit 1 of the reload word defers the copy to the edge at which a running frame wraps from its last pixel to pixel (0,0). The request reads back as pending until then.
- R8: Writes to the timing words (0x1 to 0x4) and the layer words (0x10 upward, one per layer) change neither the outputs nor the layer configuration output until a reload copies them.
- R9: Status word 0x7 holds sticky flags. Bit 0 is set when the counters sit at pixel 0 of the line held in word 0x9. Bit 1 is set by an underrun pulse, bit 2 by a transfer-error pulse and bit 3 by a completed reload.
- R10: Writing word 0x8 clears each status flag whose bit is 1 and leaves the others unchanged. A new event in the same cycle wins over the clear.
- R11: The interrupt output is high exactly when some status flag is set whose enable bit in word 0x6 (same bit positions) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| underrun_evt | input | 1 | One-cycle FIFO underrun event |
| xfer_err_evt | input | 1 | One-cycle transfer error event |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| pclk_inv_o | output | 1 | Pixel-clock inversion select |
| pos_x | output | HW | Current pixel count |
| pos_y | output | VW | Current line count |
| layer_cfg | output | 32*LAYERS | Working copies of the layer words, layer 0 lowest |
| irq_o | output | 1 | Level interrupt |

## Verification
The bound checker checks these on every cycle: counters at zero after a disabled cycle, the pixel counter stepping by one below the working total, data enable never active outside the programmed window, sticky setting of the underrun flag, write-one clearing of it, reload completion following an immediate request, and the interrupt never rising with an empty status word. The bench scenarios cover the rest. They compare two whole frames pixel by pixel against the geometry, show that a vertical-blank reload lands exactly on the frame wrap and then widens the line, confirm that staged layer and timing words stay invisible until reloaded, and exercise polarity inversion and per-bit masking.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;
   // word addresses of the register file
   localparam int A_CTL    = 0;
   localparam int A_SYNC   = 1;
   localparam int A_BP     = 2;
   localparam int A_ACT    = 3;
   localparam int A_TOT    = 4;
   localparam int A_RLD    = 5;
   localparam int A_IEN    = 6;
   localparam int A_ISTAT  = 7;
   localparam int A_ICLR   = 8;
   localparam int A_LINE   = 9;
   localparam int A_LAYER0 = 16;

   localparam int NTIM  = 4;   // timing words held in the shadow set
   localparam int H_LSB = 16;  // low bit of every horizontal field

   // control word bits
   localparam int B_EN    = 0;
   localparam int B_PCLK  = 28;
   localparam int B_DEPOL = 29;
   localparam int B_VSPOL = 30;
   localparam int B_HSPOL = 31;

   // status / enable / clear bit positions
   localparam int IRQ_LINE = 0;
   localparam int IRQ_UNDR = 1;
   localparam int IRQ_XERR = 2;
   localparam int IRQ_RLD  = 3;
   localparam int NSRC     = 4;

   // word address of shadow slot i (timing words first, then layers)
   function automatic int shadow_addr(int i);
      return (i < NTIM) ? (A_SYNC + i) : (A_LAYER0 + i - NTIM);
   endfunction
endpackage

// File: rtl/dtg_regs.sv
`timescale 1ns/1ps
module dtg_regs
   import dtg_pkg::*;
#(
   parameter int AW     = 5,
   parameter int LAYERS = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [AW-1:0]                addr,
   input  logic [31:0]                  wdata,
   input  logic [NSRC-1:0]              stat_in,
   input  logic                         frame_end,
   output logic [31:0]                  rdata,
   output logic [31:0]                  ctl,
   output logic [NSRC-1:0]              ien,
   output logic [31:0]                  line_word,
   output logic [(NTIM+LAYERS)*32-1:0]  act_flat,
   output logic                         copy,
   output logic                         clr_we,
   output logic [NSRC-1:0]              clr_mask
);
   localparam int NSH = NTIM + LAYERS;

   logic [31:0] stg [NSH];
   logic [31:0] act [NSH];
   logic        imm_pend, vb_pend;
   logic        rld_wr;

   assign rld_wr   = we && (addr == AW'(A_RLD));
   // a deferred request also completes at once while the counters are stopped
   assign copy     = imm_pend | (vb_pend & (frame_end | ~ctl[B_EN]));
   assign clr_we   = we && (addr == AW'(A_ICLR));
   assign clr_mask = wdata[NSRC-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl       <= '0;
         ien       <= '0;
         line_word <= '0;
         imm_pend  <= 1'b0;
         vb_pend   <= 1'b0;
      end else begin
         if (we && addr == AW'(A_CTL))  ctl       <= wdata;
         if (we && addr == AW'(A_IEN))  ien       <= wdata[NSRC-1:0];
         if (we && addr == AW'(A_LINE)) line_word <= wdata;
         imm_pend <= (imm_pend & ~copy) | (rld_wr & wdata[0]);
         vb_pend  <= (vb_pend  & ~copy) | (rld_wr & wdata[1]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSH; i++) begin
            stg[i] <= '0;
            act[i] <= '0;
         end
      end else begin
         for (int i = 0; i < NSH; i++) begin
            if (we && addr == AW'(shadow_addr(i))) stg[i] <= wdata;
            if (copy) act[i] <= stg[i];
         end
      end
   end

   for (genvar gi = 0; gi < NSH; gi++) begin : g_flat
      assign act_flat[gi*32 +: 32] = act[gi];
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(A_CTL))   rdata = ctl;
      if (addr == AW'(A_RLD))   rdata = {30'd0, vb_pend, imm_pend};
      if (addr == AW'(A_IEN))   rdata = 32'(ien);
      if (addr == AW'(A_ISTAT)) rdata = 32'(stat_in);
      if (addr == AW'(A_LINE))  rdata = line_word;
      for (int i = 0; i < NSH; i++)
         if (addr == AW'(shadow_addr(i))) rdata = stg[i];
   end
endmodule

// File: rtl/dtg_counters.sv
`timescale 1ns/1ps
module dtg_counters
   import dtg_pkg::*;
#(
   parameter int HW = 12,
   parameter int VW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [31:0]   sync_w,
   input  logic [31:0]   bp_w,
   input  logic [31:0]   act_w,
   input  logic [31:0]   tot_w,
   input  logic [VW-1:0] line_pos,
   input  logic [2:0]    pol,       // {hsync, vsync, de}
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic [HW-1:0] pos_x,
   output logic [VW-1:0] pos_y,
   output logic          frame_end,
   output logic          line_hit
);
   logic [HW-1:0] hcnt, h_sw, h_bp, h_ac, h_tt;
   logic [VW-1:0] vcnt, v_sw, v_bp, v_ac, v_tt;
   logic          h_end, v_end, hs_a, vs_a, de_a;
   logic          unused_fields;

   assign h_sw = sync_w[H_LSB +: HW];
   assign h_bp = bp_w[H_LSB +: HW];
   assign h_ac = act_w[H_LSB +: HW];
   assign h_tt = tot_w[H_LSB +: HW];
   assign v_sw = sync_w[VW-1:0];
   assign v_bp = bp_w[VW-1:0];
   assign v_ac = act_w[VW-1:0];
   assign v_tt = tot_w[VW-1:0];
   assign unused_fields = ^{sync_w, bp_w, act_w, tot_w};

   assign h_end = (hcnt == h_tt);
   assign v_end = (vcnt == v_tt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (!en) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (h_end) begin
         hcnt <= '0;
         vcnt <= v_end ? '0 : vcnt + 1'b1;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   assign hs_a = en && (hcnt <= h_sw);
   assign vs_a = en && (vcnt <= v_sw);
   assign de_a = en && (hcnt > h_bp) && (hcnt <= h_ac) &&
                 (vcnt > v_bp) && (vcnt <= v_ac);

   assign hsync = hs_a ? pol[2] : ~pol[2];
   assign vsync = vs_a ? pol[1] : ~pol[1];
   assign de    = de_a ? pol[0] : ~pol[0];

   assign pos_x     = hcnt;
   assign pos_y     = vcnt;
   assign frame_end = en && h_end && v_end;
   assign line_hit  = en && (hcnt == '0) && (vcnt == line_pos);
endmodule

// File: rtl/dtg_irq.sv
`timescale 1ns/1ps
module dtg_irq #(
   parameter int NS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NS-1:0] set,
   input  logic          clr_we,
   input  logic [NS-1:0] clr_mask,
   input  logic [NS-1:0] ien,
   output logic [NS-1:0] stat,
   output logic          irq
);
   for (genvar b = 0; b < NS; b++) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      q <= 1'b0;
         else if (set[b])                 q <= 1'b1;
         else if (clr_we && clr_mask[b])  q <= 1'b0;
      end
      assign stat[b] = q;
   end

   assign irq = |(stat & ien);
endmodule

// File: rtl/disp_timing_gen.sv
`timescale 1ns/1ps
module disp_timing_gen
   import dtg_pkg::*;
#(
   parameter int AW     = 5,
   parameter int HW     = 12,
   parameter int VW     = 11,
   parameter int LAYERS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [AW-1:0]        reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic                 underrun_evt,
   input  logic                 xfer_err_evt,
   output logic                 hsync_o,
   output logic                 vsync_o,
   output logic                 de_o,
   output logic                 pclk_inv_o,
   output logic [HW-1:0]        pos_x,
   output logic [VW-1:0]        pos_y,
   output logic [32*LAYERS-1:0] layer_cfg,
   output logic                 irq_o
);
   localparam int NSH = NTIM + LAYERS;

   if (HW < 2 || HW > 16) begin : g_bad_hw
      $error("HW must lie in 2..16");
   end
   if (VW < 2 || VW > 16) begin : g_bad_vw
      $error("VW must lie in 2..16");
   end
   if (LAYERS < 1 || A_LAYER0 + LAYERS > (1 << AW)) begin : g_bad_layers
      $error("LAYERS does not fit the address space");
   end

   logic [31:0]       ctl_word, line_word;
   logic [NSRC-1:0]   irq_stat, irq_en, clr_mask, ev_set;
   logic [NSH*32-1:0] act_flat;
   logic [31:0]       tim_sync, tim_bp, tim_act, tim_tot;
   logic              copy, clr_we, frame_end, line_hit;
   logic              unused_line;

   dtg_regs #(.AW(AW), .LAYERS(LAYERS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .stat_in   (irq_stat),
      .frame_end (frame_end),
      .rdata     (reg_rdata),
      .ctl       (ctl_word),
      .ien       (irq_en),
      .line_word (line_word),
      .act_flat  (act_flat),
      .copy      (copy),
      .clr_we    (clr_we),
      .clr_mask  (clr_mask)
   );

   assign tim_sync  = act_flat[0*32 +: 32];
   assign tim_bp    = act_flat[1*32 +: 32];
   assign tim_act   = act_flat[2*32 +: 32];
   assign tim_tot   = act_flat[3*32 +: 32];
   assign layer_cfg = act_flat[NSH*32-1 : NTIM*32];
   assign unused_line = ^line_word;

   dtg_counters #(.HW(HW), .VW(VW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ctl_word[B_EN]),
      .sync_w    (tim_sync),
      .bp_w      (tim_bp),
      .act_w     (tim_act),
      .tot_w     (tim_tot),
      .line_pos  (line_word[VW-1:0]),
      .pol       ({ctl_word[B_HSPOL], ctl_word[B_VSPOL], ctl_word[B_DEPOL]}),
      .hsync     (hsync_o),
      .vsync     (vsync_o),
      .de        (de_o),
      .pos_x     (pos_x),
      .pos_y     (pos_y),
      .frame_end (frame_end),
      .line_hit  (line_hit)
   );

   assign pclk_inv_o = ctl_word[B_PCLK];

   always_comb begin
      ev_set           = '0;
      ev_set[IRQ_LINE] = line_hit;
      ev_set[IRQ_UNDR] = underrun_evt;
      ev_set[IRQ_XERR] = xfer_err_evt;
      ev_set[IRQ_RLD]  = copy;
   end

   dtg_irq #(.NS(NSRC)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (ev_set),
      .clr_we   (clr_we),
      .clr_mask (clr_mask),
      .ien      (irq_en),
      .stat     (irq_stat),
      .irq      (irq_o)
   );
endmodule

module dtg_chk
   import dtg_pkg::*;
#(
   parameter int AW = 5,
   parameter int HW = 12,
   parameter int VW = 11
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_we,
   input logic [AW-1:0]   reg_addr,
   input logic [31:0]     reg_wdata,
   input logic            underrun_evt,
   input logic            de_o,
   input logic            irq_o,
   input logic [HW-1:0]   pos_x,
   input logic [VW-1:0]   pos_y,
   input logic [31:0]     ctl_word,
   input logic [NSRC-1:0] irq_stat,
   input logic [31:0]     tim_bp,
   input logic [31:0]     tim_act,
   input logic [31:0]     tim_tot
);
   logic unused_chk;
   assign unused_chk = ^{reg_wdata, ctl_word, tim_bp, tim_act, tim_tot};

   // R1
   idle_counters_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctl_word[B_EN]) |-> (pos_x == '0 && pos_y == '0));

   // R2
   pixel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctl_word[B_EN]) && $past(pos_x) != $past(tim_tot[H_LSB +: HW]))
      |-> pos_x == HW'($past(pos_x) + 1'b1));

   // R4
   de_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (de_o == ctl_word[B_DEPOL]) |->
      (pos_x > tim_bp[H_LSB +: HW] && pos_x <= tim_act[H_LSB +: HW] &&
       pos_y > tim_bp[VW-1:0] && pos_y <= tim_act[VW-1:0]));

   // R6
   imm_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == AW'(A_RLD) && reg_wdata[0]) |=> ##1 irq_stat[IRQ_RLD]);

   // R9
   underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_evt |=> irq_stat[IRQ_UNDR]);

   // R10
   underrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == AW'(A_ICLR) && reg_wdata[IRQ_UNDR] && !underrun_evt)
      |=> !irq_stat[IRQ_UNDR]);

   // R11
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (irq_stat != '0));
endmodule

bind disp_timing_gen dtg_chk #(.AW(AW), .HW(HW), .VW(VW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_we       (reg_we),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .underrun_evt (underrun_evt),
   .de_o         (de_o),
   .irq_o        (irq_o),
   .pos_x        (pos_x),
   .pos_y        (pos_y),
   .ctl_word     (ctl_word),
   .irq_stat     (irq_stat),
   .tim_bp       (tim_bp),
   .tim_act      (tim_act),
   .tim_tot      (tim_tot)
);

// File: tb/test_disp_timing_gen.sv
`timescale 1ns/1ps
module test_disp_timing_gen;
   import dtg_pkg::*;
   localparam int AW = 5, HW = 12, VW = 11, LAYERS = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic                 reg_we = 1'b0;
   logic [AW-1:0]        reg_addr = '0;
   logic [31:0]          reg_wdata = '0;
   logic [31:0]          reg_rdata;
   logic                 underrun_evt = 1'b0, xfer_err_evt = 1'b0;
   logic                 hsync_o, vsync_o, de_o, pclk_inv_o, irq_o;
   logic [HW-1:0]        pos_x;
   logic [VW-1:0]        pos_y;
   logic [32*LAYERS-1:0] layer_cfg;

   disp_timing_gen #(.AW(AW), .HW(HW), .VW(VW), .LAYERS(LAYERS)) i_disp_timing_gen (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .underrun_evt(underrun_evt),
      .xfer_err_evt(xfer_err_evt), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
      .pclk_inv_o(pclk_inv_o), .pos_x(pos_x), .pos_y(pos_y), .layer_cfg(layer_cfg),
      .irq_o(irq_o)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // geometry in plain lengths
   int hsl = 2, hbp = 2, hact = 4, hfp = 2;
   int vsl = 1, vbp = 1, vact = 3, vfp = 1;

   logic [25:0] sbq [$];
   bit          mon_on = 1'b0;

   task automatic check(string req, logic [63:0] actual, logic [63:0] expected);
      n_chk++;
      if (actual !== expected) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic wr_arm(int a, logic [31:0] d);
      @(negedge clk);
      mon_on = 1'b1;
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      reg_addr = AW'(a);
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [31:0] hv(int h, int v);
      return (32'(h) << 16) | 32'(v);
   endfunction

   function automatic logic [25:0] exp_px(int x, int y);
      logic hs, vs, de;
      hs = (x < hsl);
      vs = (y < vsl);
      de = (x >= hsl + hbp) && (x < hsl + hbp + hact) &&
           (y >= vsl + vbp) && (y < vsl + vbp + vact);
      // low-active encoding: an active signal reads 0
      return {~hs, ~vs, ~de, HW'(x), VW'(y)};
   endfunction

   task automatic program_timing();
      wr(A_SYNC, hv(hsl - 1, vsl - 1));
      wr(A_BP,   hv(hsl - 1 + hbp, vsl - 1 + vbp));
      wr(A_ACT,  hv(hsl - 1 + hbp + hact, vsl - 1 + vbp + vact));
      wr(A_TOT,  hv(hsl - 1 + hbp + hact + hfp, vsl - 1 + vbp + vact + vfp));
   endtask

   task automatic pulse(bit which);
      @(negedge clk);
      if (which) xfer_err_evt = 1'b1; else underrun_evt = 1'b1;
      @(negedge clk);
      xfer_err_evt = 1'b0; underrun_evt = 1'b0;
   endtask

   // scoreboard monitor: one expected pixel per cycle, sampled after the edge
   always @(posedge clk) begin
      #1;
      if (mon_on && sbq.size() > 0) begin
         logic [25:0] e;
         e = sbq.pop_front();
         // R2 R3 R4 frame scan
         check("R2/R3/R4 pixel", {hsync_o, vsync_o, de_o, pos_x, pos_y}, e);
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int maxx;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset / idle state
      check("R1 idle syncs", {hsync_o, vsync_o, de_o}, 3'b111);
      check("R1 idle position", {pos_x, pos_y}, '0);
      // R5 polarity bits default to 0
      check("R5 pclk default", pclk_inv_o, 1'b0);
      check("R11 irq reset", irq_o, 1'b0);

      program_timing();
      wr(A_LINE, 32'(vsl + vbp + vact));
      wr(A_LAYER0,     32'hA5A5_0001);
      wr(A_LAYER0 + 1, 32'h5A5A_0002);
      // R8 staged words invisible before reload
      check("R8 layers before reload", layer_cfg, '0);
      rd(A_TOT, d);
      check("R8 staged readback", d, hv(9, 5));

      wr(A_RLD, 32'h1);
      rd(A_RLD, d);
      // R6 pending visible right after the request
      check("R6 pending", d, 32'h1);
      @(negedge clk);
      rd(A_RLD, d);
      check("R6 self-clear", d, 32'h0);
      check("R6 layers copied", layer_cfg, {32'h5A5A_0002, 32'hA5A5_0001});
      rd(A_ISTAT, d);
      // R9 reload-done flag
      check("R9 reload flag", d[IRQ_RLD], 1'b1);
      wr(A_ICLR, 32'hF);

      // two full frames through the scoreboard
      for (int f = 0; f < 2; f++)
         for (int y = 0; y <= vsl + vbp + vact + vfp - 1; y++)
            for (int x = 0; x <= hsl + hbp + hact + hfp - 1; x++)
               sbq.push_back(exp_px(x, y));
      wr_arm(A_CTL, 32'h1);
      repeat (125) @(negedge clk);
      mon_on = 1'b0;
      check("R2 scoreboard drained", 32'(sbq.size()), 32'd0);
      rd(A_ISTAT, d);
      // R9 line event seen, R11 masked
      check("R9 line flag", d[IRQ_LINE], 1'b1);
      check("R11 masked irq", irq_o, 1'b0);
      wr(A_IEN, 32'h1);
      check("R11 enabled irq", irq_o, 1'b1);

      // deferred reload with a wider line
      wr(A_ICLR, 32'h8);
      hfp = 4;
      wr(A_TOT, hv(hsl - 1 + hbp + hact + hfp, vsl - 1 + vbp + vact + vfp));
      wr(A_RLD, 32'h2);
      rd(A_RLD, d);
      // R7 pending until frame wrap
      check("R7 pending", d, 32'h2);
      seen = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         rd(A_ISTAT, d);
         if (d[IRQ_RLD]) begin seen = 1'b1; break; end
      end
      check("R7 copy happened", seen, 1'b1);
      check("R7 copy at frame wrap", {pos_x, pos_y}, '0);
      rd(A_RLD, d);
      check("R7 pending cleared", d, 32'h0);
      maxx = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk); #1;
         if (int'(pos_x) > maxx) maxx = int'(pos_x);
      end
      // R2 new total width takes effect
      check("R2 wrap at new total", 32'(maxx), 32'd11);

      wr(A_CTL, 32'h0);
      wr(A_ICLR, 32'hF);
      #1;
      check("R1 stopped position", {pos_x, pos_y}, '0);
      check("R1 stopped syncs", {hsync_o, vsync_o, de_o}, 3'b111);
      rd(A_ISTAT, d);
      check("R10 clear all", d, 32'h0);
      check("R11 irq low after clear", irq_o, 1'b0);
      wr(A_IEN, 32'h2);
      pulse(1'b0);
      rd(A_ISTAT, d);
      check("R9 underrun flag", d, 32'h2);
      check("R11 underrun irq", irq_o, 1'b1);
      pulse(1'b1);
      rd(A_ISTAT, d);
      check("R9 transfer error flag", d, 32'h6);
      wr(A_ICLR, 32'h2);
      rd(A_ISTAT, d);
      // R10 only the written bit clears
      check("R10 partial clear", d, 32'h4);
      check("R11 masked remaining flag", irq_o, 1'b0);

      wr(A_CTL, 32'hF000_0000);
      #1;
      // R5 inverted idle levels
      check("R5 high-active idle", {hsync_o, vsync_o, de_o}, 3'b000);
      check("R5 pclk select", pclk_inv_o, 1'b1);
      wr(A_CTL, 32'hF000_0001);
      #1;
      check("R5 high-active at origin", {hsync_o, vsync_o, de_o, pos_x, pos_y},
            {3'b110, HW'(0), VW'(0)});

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule